// File: doc/BRIEF.md
# Cascaded Timer Divisor Pair Solver

This block works out how to load two chained down-counters so that their combined period comes as close as possible to a requested period. The request arrives as a period in nanoseconds, together with the period of the oscillator that feeds the first counter and a rounding mode. The block searches over pairs of divisors and returns them in the 16-bit counter encoding, together with the period that the pair actually produces. It is a sequential engine. A search takes a variable number of cycles, and only one request is handled at a time.

The caller may also pass in the divisor pair that is currently loaded. If that pair is legal and already gives exactly the requested period, the engine skips the search and hands the pair back at once. The engine is not a stream block. `start`, `busy` and `done` are plain control pins. There is no back-pressure: a result stays on the outputs until the next request is accepted, and the caller reads it whenever it likes.

Top module: `dps_solver`

## Requirements
- R1: Every reported divisor, once decoded, lies between 2 and 2^CNT_W inclusive. A divisor code is the divisor value modulo 2^CNT_W, so 2^CNT_W is reported as code 0.
- R2: A seed code of 0 stands for 2^CNT_W. If both decoded seeds are greater than 1 and their product times the base period equals the request exactly, the engine returns the seed codes unchanged and returns the request as the achieved period. In that case `done` rises on the second rising edge, counting the edge that accepts `start`.
- R3: The search uses T = floor(request / base). The outer divisor a starts at max(2, floor(T / 2^CNT_W)) and continues while a <= floor(T/a)+1 and a <= 2^CNT_W. For each a, the inner divisor b starts at max(2, floor(T/a)) and continues while a*b <= T+a+1 and b <= 2^CNT_W. A candidate replaces the best-below or best-above pair only on a strict improvement, so the earliest candidate in search order wins a tie.
- R4: Mode 2'b10 (up) returns the smallest candidate period that is at or above the request.
- R5: Mode 2'b01 (down) returns the largest candidate period that is at or below the request.
- R6: Modes 2'b00 and 2'b11 (nearest) return the pair above only when its distance to the request is strictly smaller than the distance of the pair below. An equal distance goes to the pair below.
- R7: When no candidate lies below, the pair above is returned in every mode, and when none lies above, the pair below is returned. When there is no candidate at all, the engine returns (2,2) if T < 4 and (2^CNT_W, 2^CNT_W) otherwise.
- R8: The achieved period output equals the product of the two decoded divisors and the base period.
- R9: `start` is accepted only while `busy` is low. `busy` is high from the accepting edge until the result is posted. `done` is a one-cycle pulse in the cycle in which `busy` falls. A `start` pulse while `busy` is high is ignored. The outputs hold their values until the next accepted request.
- R10: After reset, `busy`, `done`, both divisor codes and the achieved period are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled while idle |
| req_ns | input | NS_W | Requested period in ns |
| base_ns | input | BASE_W | Oscillator period in ns, must be nonzero |
| round_mode | input | 2 | 00/11 nearest, 01 down, 10 up |
| seed_div1 | input | CNT_W | Currently loaded first divisor code |
| seed_div2 | input | CNT_W | Currently loaded second divisor code |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| div1_code | output | CNT_W | First divisor, counter encoding |
| div2_code | output | CNT_W | Second divisor, counter encoding |
| achieved_ns | output | 2*(CNT_W+1)+BASE_W | Period produced by the returned pair |

## Verification
The bench uses a 4-bit counter configuration and sweeps the requested period densely for several base periods in all four modes. Each result is compared with an arithmetic model of the search order. This exposes an engine that breaks ties in the wrong direction, treats mode 11 differently from nearest, or lets the inner divisor start below 2. The sweep includes requests too small to give any candidate and requests above the largest reachable product. A wrong fallback there would return an illegal or far-off pair. The bench also tests seeds that match exactly, seeds that are off by one nanosecond, and seeds that use code 0 or 1. An engine that decodes 0 wrongly or accepts a divisor of 1 would take the wrong path or report the wrong latency. A `start` pulse issued mid-search, and input changes made after completion, must leave the result untouched.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic [1:0] {
    RND_NEAREST     = 2'b00,
    RND_DOWN        = 2'b01,
    RND_UP          = 2'b10,
    RND_NEAREST_ALT = 2'b11
  } rnd_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEED,
    ST_TDIV,
    ST_OLAUNCH,
    ST_ODIV,
    ST_INNER,
    ST_PICK
  } srch_state_e;

endpackage

// File: rtl/dps_divider.sv
module dps_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quot
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]   rem;
  logic [W-1:0] qsh;
  logic [W-1:0] den_r;
  logic [W-1:0] num_r;
  logic [CW-1:0] cnt;
  logic [W:0]   shifted;
  logic [W+1:0] diff;
  logic         fits;

  // Restoring step: shift in the next dividend bit, try to subtract the divisor.
  assign shifted = {rem[W-1:0], qsh[W-1]};
  assign diff    = {1'b0, shifted} - {2'b00, den_r};
  assign fits    = ~diff[W+1];
  assign quot    = qsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem   <= '0;
      qsh   <= '0;
      den_r <= '0;
      num_r <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        rem   <= '0;
        qsh   <= num;
        den_r <= den;
        num_r <= num;
        cnt   <= CW'(W);
        busy  <= 1'b1;
      end else if (busy) begin
        rem <= fits ? diff[W:0] : shifted;
        qsh <= {qsh[W-2:0], fits};
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && den_r != '0) |->
      ((2*W)'(quot) * (2*W)'(den_r) <= (2*W)'(num_r)) &&
      (((2*W)'(quot) + (2*W)'(1)) * (2*W)'(den_r) > (2*W)'(num_r))); // R3

  AST_DIV_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy); // R3

endmodule

// File: rtl/dps_seed_check.sv
module dps_seed_check #(
  parameter int CNT_W  = 16,
  parameter int NS_W   = 32,
  parameter int BASE_W = 32,
  parameter int AW     = 2 * (CNT_W + 1) + BASE_W
) (
  input  logic [CNT_W-1:0]  seed_a,
  input  logic [CNT_W-1:0]  seed_b,
  input  logic [BASE_W-1:0] base,
  input  logic [NS_W-1:0]   req,
  output logic              hit,
  output logic [CNT_W:0]    dec_a,
  output logic [CNT_W:0]    dec_b
);
  localparam logic [CNT_W:0] TOP = {1'b1, {CNT_W{1'b0}}};

  logic [AW-1:0] prod;

  assign dec_a = (seed_a == '0) ? TOP : {1'b0, seed_a};
  assign dec_b = (seed_b == '0) ? TOP : {1'b0, seed_b};
  assign prod  = AW'(dec_a) * AW'(dec_b) * AW'(base);
  assign hit   = (dec_a > (CNT_W+1)'(1)) && (dec_b > (CNT_W+1)'(1)) &&
                 (prod == AW'(req));

endmodule

// File: rtl/dps_pick.sv
module dps_pick
  import dps_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NS_W  = 32,
  parameter int AW    = 66
) (
  input  rnd_mode_e      mode,
  input  logic [NS_W-1:0] req,
  input  logic           target_small,
  input  logic           lo_v,
  input  logic [AW-1:0]  lo_ns,
  input  logic [CNT_W:0] lo_a,
  input  logic [CNT_W:0] lo_b,
  input  logic           hi_v,
  input  logic [AW-1:0]  hi_ns,
  input  logic [CNT_W:0] hi_a,
  input  logic [CNT_W:0] hi_b,
  output logic [CNT_W:0] sel_a,
  output logic [CNT_W:0] sel_b
);
  localparam logic [CNT_W:0] TOP = {1'b1, {CNT_W{1'b0}}};
  localparam logic [CNT_W:0] TWO = (CNT_W+1)'(2);

  logic [AW-1:0] gap_hi;
  logic [AW-1:0] gap_lo;
  logic          take_hi;

  assign gap_hi = hi_ns - AW'(req);
  assign gap_lo = AW'(req) - lo_ns;

  always_comb begin
    unique case (mode)
      RND_UP:   take_hi = 1'b1;
      RND_DOWN: take_hi = 1'b0;
      default:  take_hi = (gap_hi < gap_lo);
    endcase
  end

  always_comb begin
    if (!lo_v && !hi_v) begin
      sel_a = target_small ? TWO : TOP;
      sel_b = target_small ? TWO : TOP;
    end else if (!lo_v || (hi_v && take_hi)) begin
      sel_a = hi_a;
      sel_b = hi_b;
    end else begin
      sel_a = lo_a;
      sel_b = lo_b;
    end
  end

endmodule

// File: rtl/dps_solver.sv
module dps_solver
  import dps_pkg::*;
#(
  parameter int NS_W   = 32,
  parameter int BASE_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [NS_W-1:0]               req_ns,
  input  logic [BASE_W-1:0]             base_ns,
  input  logic [1:0]                    round_mode,
  input  logic [CNT_W-1:0]              seed_div1,
  input  logic [CNT_W-1:0]              seed_div2,
  output logic                          busy,
  output logic                          done,
  output logic [CNT_W-1:0]              div1_code,
  output logic [CNT_W-1:0]              div2_code,
  output logic [2*(CNT_W+1)+BASE_W-1:0] achieved_ns
);
  localparam int MAXV = 1 << CNT_W;
  localparam int AW   = 2 * (CNT_W + 1) + BASE_W;
  localparam int LW0  = (NS_W > CNT_W + 1) ? NS_W : CNT_W + 1;
  localparam int LW   = ((LW0 > BASE_W) ? LW0 : BASE_W) + 2;
  localparam int PW   = 2 * LW;

  srch_state_e state;

  logic [NS_W-1:0]   req_r;
  logic [BASE_W-1:0] base_r;
  rnd_mode_e         mode_r;
  logic [CNT_W-1:0]  seed1_r, seed2_r;
  logic [LW-1:0]     target_r;
  logic [LW-1:0]     o_d, i_d;
  logic              lo_v, hi_v;
  logic [AW-1:0]     lo_ns, hi_ns;
  logic [CNT_W:0]    lo_a, lo_b, hi_a, hi_b;
  logic              fast_r;
  logic [CNT_W-1:0]  d1c_r, d2c_r;
  logic [AW-1:0]     ach_r;
  logic              done_r;

  // divider hookup
  logic          div_go, div_busy, div_done;
  logic [LW-1:0] div_num, div_den, div_quot;

  assign div_go  = (state == ST_SEED && !seed_hit) || (state == ST_OLAUNCH);
  assign div_num = (state == ST_SEED) ? LW'(req_r)  : target_r;
  assign div_den = (state == ST_SEED) ? LW'(base_r) : o_d;

  dps_divider #(.W(LW)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (div_go),
    .num   (div_num),
    .den   (div_den),
    .busy  (div_busy),
    .done  (div_done),
    .quot  (div_quot)
  );

  // seed shortcut
  logic           seed_hit;
  logic [CNT_W:0] seed_dec1, seed_dec2;

  dps_seed_check #(
    .CNT_W (CNT_W), .NS_W (NS_W), .BASE_W (BASE_W), .AW (AW)
  ) u_seed (
    .seed_a (seed1_r),
    .seed_b (seed2_r),
    .base   (base_r),
    .req    (req_r),
    .hit    (seed_hit),
    .dec_a  (seed_dec1),
    .dec_b  (seed_dec2)
  );

  // search arithmetic
  logic [LW-1:0] tq_hi, start_d;
  logic          outer_go, inner_go;
  logic [PW-1:0] prod_oi, inner_lim;
  logic [AW-1:0] cand_ns, req_w;

  assign tq_hi     = div_quot >> CNT_W;
  assign start_d   = (tq_hi < LW'(2)) ? LW'(2) : tq_hi;
  assign outer_go  = (o_d <= div_quot + LW'(1)) && (o_d <= LW'(MAXV));
  assign prod_oi   = PW'(o_d) * PW'(i_d);
  assign inner_lim = PW'(target_r) + PW'(o_d) + PW'(1);
  assign inner_go  = (prod_oi <= inner_lim) && (i_d <= LW'(MAXV));
  assign cand_ns   = AW'(o_d[CNT_W:0]) * AW'(i_d[CNT_W:0]) * AW'(base_r);
  assign req_w     = AW'(req_r);

  // rounding choice
  logic [CNT_W:0] sel_a, sel_b;
  logic [AW-1:0]  pick_ach;

  dps_pick #(.CNT_W (CNT_W), .NS_W (NS_W), .AW (AW)) u_pick (
    .mode         (mode_r),
    .req          (req_r),
    .target_small (target_r < LW'(4)),
    .lo_v         (lo_v),
    .lo_ns        (lo_ns),
    .lo_a         (lo_a),
    .lo_b         (lo_b),
    .hi_v         (hi_v),
    .hi_ns        (hi_ns),
    .hi_a         (hi_a),
    .hi_b         (hi_b),
    .sel_a        (sel_a),
    .sel_b        (sel_b)
  );

  assign pick_ach = AW'(sel_a) * AW'(sel_b) * AW'(base_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      req_r    <= '0;
      base_r   <= '0;
      mode_r   <= RND_NEAREST;
      seed1_r  <= '0;
      seed2_r  <= '0;
      target_r <= '0;
      o_d      <= '0;
      i_d      <= '0;
      lo_v     <= 1'b0;
      hi_v     <= 1'b0;
      lo_ns    <= '0;
      hi_ns    <= '0;
      lo_a     <= '0;
      lo_b     <= '0;
      hi_a     <= '0;
      hi_b     <= '0;
      fast_r   <= 1'b0;
      d1c_r    <= '0;
      d2c_r    <= '0;
      ach_r    <= '0;
      done_r   <= 1'b0;
    end else begin
      done_r <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            req_r   <= req_ns;
            base_r  <= base_ns;
            mode_r  <= rnd_mode_e'(round_mode);
            seed1_r <= seed_div1;
            seed2_r <= seed_div2;
            lo_v    <= 1'b0;
            hi_v    <= 1'b0;
            fast_r  <= 1'b0;
            state   <= ST_SEED;
          end
        end
        ST_SEED: begin
          if (seed_hit) begin
            d1c_r  <= seed1_r;
            d2c_r  <= seed2_r;
            ach_r  <= req_w;
            fast_r <= 1'b1;
            done_r <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            state <= ST_TDIV;
          end
        end
        ST_TDIV: begin
          if (div_done) begin
            target_r <= div_quot;
            o_d      <= start_d;
            state    <= ST_OLAUNCH;
          end
        end
        ST_OLAUNCH: state <= ST_ODIV;
        ST_ODIV: begin
          if (div_done) begin
            if (outer_go) begin
              i_d   <= (div_quot < LW'(2)) ? LW'(2) : div_quot;
              state <= ST_INNER;
            end else begin
              state <= ST_PICK;
            end
          end
        end
        ST_INNER: begin
          if (inner_go) begin
            if (cand_ns <= req_w && (!lo_v || cand_ns > lo_ns)) begin
              lo_v  <= 1'b1;
              lo_ns <= cand_ns;
              lo_a  <= o_d[CNT_W:0];
              lo_b  <= i_d[CNT_W:0];
            end
            if (cand_ns >= req_w && (!hi_v || cand_ns < hi_ns)) begin
              hi_v  <= 1'b1;
              hi_ns <= cand_ns;
              hi_a  <= o_d[CNT_W:0];
              hi_b  <= i_d[CNT_W:0];
            end
            i_d <= i_d + LW'(1);
          end else begin
            o_d   <= o_d + LW'(1);
            state <= ST_OLAUNCH;
          end
        end
        ST_PICK: begin
          d1c_r  <= sel_a[CNT_W-1:0];
          d2c_r  <= sel_b[CNT_W-1:0];
          ach_r  <= pick_ach;
          done_r <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state != ST_IDLE);
  assign done        = done_r;
  assign div1_code   = d1c_r;
  assign div2_code   = d2c_r;
  assign achieved_ns = ach_r;

  // decoded outputs for the checks below
  logic [AW-1:0] out_dec1, out_dec2;
  assign out_dec1 = (div1_code == '0) ? AW'(MAXV) : AW'(div1_code);
  assign out_dec2 = (div2_code == '0) ? AW'(MAXV) : AW'(div2_code);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R9

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (div1_code != CNT_W'(1)) && (div2_code != CNT_W'(1))); // R1

  AST_ACH_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> achieved_ns == out_dec1 * out_dec2 * AW'(base_r)); // R8

  AST_FAST_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fast_r) |-> achieved_ns == req_w); // R2

  AST_UP_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fast_r && mode_r == RND_UP && hi_v) |-> achieved_ns >= req_w); // R4

  AST_DOWN_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fast_r && mode_r == RND_DOWN && lo_v) |-> achieved_ns <= req_w); // R5

  AST_LAUNCH_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OLAUNCH) |-> !div_busy); // R3

endmodule

// File: tb/dps_solver_bench.sv
module dps_solver_bench;
  localparam int NS_W   = 10;
  localparam int BASE_W = 4;
  localparam int CNT_W  = 4;
  localparam int AW     = 2 * (CNT_W + 1) + BASE_W;
  localparam int MX     = 1 << CNT_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [NS_W-1:0]   req_ns = '0;
  logic [BASE_W-1:0] base_ns = '0;
  logic [1:0]        round_mode = '0;
  logic [CNT_W-1:0]  seed_div1 = '0, seed_div2 = '0;
  logic              busy, done;
  logic [CNT_W-1:0]  div1_code, div2_code;
  logic [AW-1:0]     achieved_ns;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dps_solver #(.NS_W(NS_W), .BASE_W(BASE_W), .CNT_W(CNT_W)) u_dps_solver (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .req_ns      (req_ns),
    .base_ns     (base_ns),
    .round_mode  (round_mode),
    .seed_div1   (seed_div1),
    .seed_div2   (seed_div2),
    .busy        (busy),
    .done        (done),
    .div1_code   (div1_code),
    .div2_code   (div2_code),
    .achieved_ns (achieved_ns)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    end
  endtask

  // Arithmetic model of the requirements (R2, R3, R4-R7, R1 encoding).
  function automatic void model(input int req, input int base, input int mode,
                                input int s1, input int s2,
                                output int e1, output int e2, output int ea,
                                output bit fast);
    int a, b, t, st, lns, hns, la, lb, ha, hb, sa, sb, ns, y0;
    bit lv, hv, up;
    a = (s1 == 0) ? MX : s1;
    b = (s2 == 0) ? MX : s2;
    fast = 1'b0;
    if (a > 1 && b > 1 && a * b * base == req) begin
      e1 = s1; e2 = s2; ea = req; fast = 1'b1;
      return;
    end
    t = req / base;
    st = t / MX;
    if (st < 2) st = 2;
    lv = 0; hv = 0; lns = 0; hns = 0; la = 0; lb = 0; ha = 0; hb = 0;
    for (int x = st; x <= t / x + 1 && x <= MX; x++) begin
      y0 = (t / x < 2) ? 2 : t / x;
      for (int y = y0; x * y <= t + x + 1 && y <= MX; y++) begin
        ns = x * y * base;
        if (ns <= req && (!lv || ns > lns)) begin lv = 1; lns = ns; la = x; lb = y; end
        if (ns >= req && (!hv || ns < hns)) begin hv = 1; hns = ns; ha = x; hb = y; end
      end
    end
    if (mode == 2) up = 1;
    else if (mode == 1) up = 0;
    else up = (hns - req) < (req - lns);
    if (!lv && !hv) begin
      sa = (t < 4) ? 2 : MX; sb = sa;
    end else if (!lv || (hv && up)) begin
      sa = ha; sb = hb;
    end else begin
      sa = la; sb = lb;
    end
    e1 = sa % MX; e2 = sb % MX; ea = sa * sb * base;
  endfunction

  // One request; returns number of negedges from start drive to done.
  task automatic run(input int req, input int base, input int mode,
                     input int s1, input int s2, input string tag,
                     output int lat);
    int e1, e2, ea, d1v, d2v;
    bit fast;
    @(negedge clk);
    req_ns = NS_W'(req); base_ns = BASE_W'(base); round_mode = 2'(mode);
    seed_div1 = CNT_W'(s1); seed_div2 = CNT_W'(s2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 4000) begin
      @(negedge clk);
      lat++;
    end
    chk(done === 1'b1, "R9", "done seen", longint'(done), 1);
    model(req, base, mode, s1, s2, e1, e2, ea, fast);
    chk(div1_code == CNT_W'(e1), tag, "div1_code", div1_code, e1);
    chk(div2_code == CNT_W'(e2), tag, "div2_code", div2_code, e2);
    chk(achieved_ns == AW'(ea), tag, "achieved_ns", achieved_ns, ea);
    d1v = (div1_code == 0) ? MX : int'(div1_code);
    d2v = (div2_code == 0) ? MX : int'(div2_code);
    chk(d1v >= 2 && d2v >= 2, "R1", "decoded divisor min", (d1v < d2v) ? d1v : d2v, 2);
    chk(int'(achieved_ns) == d1v * d2v * base, "R8", "achieved product",
        achieved_ns, d1v * d2v * base);
    if (fast) chk(lat == 2, "R2", "shortcut latency", lat, 2);
  endtask

  function automatic string mode_tag(input int mode);
    if (mode == 2) return "R3 R4";
    if (mode == 1) return "R3 R5";
    return "R3 R6";
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 0, 1);
    report();
    $finish;
  end

  initial begin
    int lat;
    logic [CNT_W-1:0] h1, h2;
    logic [AW-1:0] ha;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(busy == 1'b0 && done == 1'b0, "R10", "busy/done in reset", {busy, done}, 0);
    chk(div1_code == '0 && div2_code == '0 && achieved_ns == '0, "R10",
        "outputs in reset", achieved_ns, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: shortcut with exact seeds, code 0 meaning full range
    run(60, 3, 2, 4, 5, "R2", lat);
    run(48, 1, 0, 0, 3, "R2", lat);
    run(61, 3, 0, 4, 5, "R2 R6", lat);   // off by one: search
    run(12, 1, 1, 1, 12, "R2 R5", lat);  // divisor 1 is not legal
    run(256, 1, 3, 0, 0, "R2", lat);

    // R7: fallbacks
    run(1, 1, 1, 1, 1, "R7", lat);     // no candidate, small target
    run(3, 1, 1, 1, 1, "R7", lat);     // nothing below, down mode
    run(7, 2, 0, 1, 1, "R7", lat);
    run(261, 1, 2, 1, 1, "R7", lat);   // nothing above, up mode
    run(1000, 1, 2, 1, 1, "R7", lat);  // nothing at all, large target
    run(1000, 3, 1, 1, 1, "R7", lat);

    // Sweeps across modes
    for (int r = 0; r <= 130; r++)
      for (int m = 0; m < 4; m++) run(r, 1, m, 1, 1, mode_tag(m), lat);
    for (int r = 0; r <= 700; r += 13)
      for (int m = 0; m < 4; m++) run(r, 3, m, 1, 1, mode_tag(m), lat);
    for (int r = 20; r <= 1000; r += 37)
      for (int m = 0; m < 3; m++) run(r, 5, m, 1, 1, mode_tag(m), lat);

    // R9: start while busy is ignored
    @(negedge clk);
    req_ns = 10'd100; base_ns = 4'd1; round_mode = 2'd0;
    seed_div1 = '0; seed_div2 = 4'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9", "busy after accept", busy, 1);
    repeat (3) @(negedge clk);
    req_ns = 10'd50; base_ns = 4'd2; round_mode = 2'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 4000) begin @(negedge clk); lat++; end
    chk(busy == 1'b0, "R9", "busy low with done", busy, 0);
    begin
      int e1, e2, ea; bit f;
      model(100, 1, 0, 0, 1, e1, e2, ea, f);
      chk(achieved_ns == AW'(ea) && div1_code == CNT_W'(e1) && div2_code == CNT_W'(e2),
          "R9", "mid-search start ignored", achieved_ns, ea);
    end
    @(negedge clk);
    chk(done == 1'b0, "R9", "done one cycle", done, 0);

    // R9: outputs hold without a new start
    h1 = div1_code; h2 = div2_code; ha = achieved_ns;
    req_ns = 10'd999; base_ns = 4'd7; round_mode = 2'd1;
    repeat (6) @(negedge clk);
    chk(div1_code == h1 && div2_code == h2 && achieved_ns == ha, "R9",
        "result held", achieved_ns, ha);
    chk(busy == 1'b0, "R9", "stays idle", busy, 0);

    report();
    $finish;
  end

endmodule